// File: doc/BRIEF.md
# Boot-Sector Map and Write-Protect Checker

This block decides whether a read, program or erase request aimed at an 18-bit byte address of a 256 KB flash array may proceed. It decodes the address onto the array's sector layout and returns a sector index together with an allow or deny verdict. The layout depends on the operation:

- Reads, programs and fine erases use a seven-sector map with small sectors near the top.
- Uniform erases see four equal 64 KB sectors.

Two active-low hardware pins add protection on top of a bank of per-sector lock bits:

- The boot-lock pin guards the boot region.
- The write-protect pin guards every other sector.

A command sequencer presents a request with a one-cycle strobe and receives the registered verdict on the following cycle. Firmware sets the lock bits through a small write port. The pins only add protection and never alter the lock bits.

Top module: `bootmap_guard`

## Requirements
- R1: For reads, programs and fine erases, `rsp_sector` equals the fine sector index. Sector 6 spans 0x3C000–0x3FFFF, 5 spans 0x3A000–0x3BFFF, 4 spans 0x38000–0x39FFF, 3 spans 0x30000–0x37FFF, and 2, 1 and 0 are the 64 KB ranges at 0x20000, 0x10000 and 0x00000. The `req_op` encoding is 0 read, 1 program, 2 fine erase, 3 uniform erase.
- R2: For a uniform erase, `rsp_sector` equals address bits 17:16, which selects one of four 64 KB sectors.
- R3: While `tbl_n` is low, a program or fine erase to fine sector 6 is denied, whatever the lock bits hold.
- R4: While `tbl_n` is low, a uniform erase to any address in 0x30000–0x3FFFF is denied. Programs and fine erases to fine sectors 3–5 are not affected by `tbl_n`.
- R5: While `wp_n` is low, programs and erases outside the boot region are denied. For programs and fine erases the boot region is fine sector 6. For uniform erases it is uniform sector 3.
- R6: With both pins high, a program or fine erase is denied exactly when the target fine sector's write-lock bit is set. A uniform erase to sector 0–2 checks that sector's write-lock bit. A uniform erase to sector 3 is denied if any of fine sectors 3–6 is write-locked. Pin levels never change the lock bits.
- R7: A read is denied exactly when the target fine sector's read-lock bit is set. Pins and write-lock bits have no effect on reads.
- R8: Lock port writes have the following effects:
  - A write with `lk_we` high and `lk_sel` from 0 to 6 loads that sector's write-lock bit from `lk_wdata[0]` and its read-lock bit from `lk_wdata[1]`.
  - A write with `lk_sel` of 7 changes nothing.
  - After reset, all lock bits are clear.
- R9: `rsp_vld` rises in the cycle after a `req_vld` strobe, with exactly one of `rsp_allow` and `rsp_deny` high. Without a strobe, all response outputs are low on the next cycle.
- R10: During reset, all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 0 read, 1 program, 2 fine erase, 3 uniform erase |
| req_addr | input | 18 | Target byte address |
| tbl_n | input | 1 | Boot-region lock pin, active low |
| wp_n | input | 1 | Write-protect pin for non-boot sectors, active low |
| lk_we | input | 1 | Lock register write enable |
| lk_sel | input | 3 | Lock register sector select |
| lk_wdata | input | 2 | Bit 0 write-lock, bit 1 read-lock |
| rsp_vld | output | 1 | Response valid |
| rsp_allow | output | 1 | Request may proceed |
| rsp_deny | output | 1 | Request refused |
| rsp_sector | output | 3 | Decoded sector index |

## Verification
The sweep covers both ends of every 8 KB slice for every operation, pin combination and lock pattern. The 0x37FFF/0x38000 and 0x3BFFF/0x3C000 edges catch a decoder that splits the top 64 KB at the wrong bit; such a decoder would report the wrong index or place the boot lock on the wrong range. Uniform erases to the top region with only one fine sub-sector locked expose a design that checks only one lock bit and would wrongly allow the erase. Reads under low pins and full write locks reveal pin leakage into reads, which shows up as spurious denies. A write to select 7 followed by a sweep shows whether the invalid select aliases onto a real sector, which would leave it unexpectedly locked.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
  localparam int unsigned ADDR_W = 18;
  localparam int unsigned N_FINE = 7;
  localparam int unsigned SECT_W = 3;
  localparam int unsigned UNI_W  = 2;
  localparam int unsigned LKD_W  = 2;

  typedef enum logic [1:0] {
    OP_READ       = 2'd0,
    OP_PROG       = 2'd1,
    OP_ERASE_FINE = 2'd2,
    OP_ERASE_UNI  = 2'd3
  } op_e;
endpackage

// File: rtl/bootmap_decode.sv
module bootmap_decode
  import bootmap_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned SW = SECT_W,
  parameter int unsigned UW = UNI_W
) (
  input  logic [AW-1:0] addr,
  output logic [SW-1:0] fine_idx,
  output logic [UW-1:0] uni_idx
);
  // top quarter is split at bit AW-3 (32 KB), then AW-4 (16 KB), then AW-5 (8 KB)
  localparam int unsigned B32 = AW - 3;
  localparam int unsigned B16 = AW - 4;
  localparam int unsigned B8  = AW - 5;

  always_comb begin
    uni_idx = addr[AW-1 -: UW];
    if (uni_idx != {UW{1'b1}}) begin
      fine_idx = SW'(uni_idx);
    end else if (!addr[B32]) begin
      fine_idx = SW'(3);
    end else if (addr[B16]) begin
      fine_idx = SW'(6);
    end else if (addr[B8]) begin
      fine_idx = SW'(5);
    end else begin
      fine_idx = SW'(4);
    end
  end
endmodule

// File: rtl/bootmap_lockbank.sv
module bootmap_lockbank
  import bootmap_pkg::*;
#(
  parameter int unsigned NS = N_FINE,
  parameter int unsigned SW = SECT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] sel,
  input  logic [1:0]    wdata,
  output logic [NS-1:0] wlock,
  output logic [NS-1:0] rlock
);
  logic [NS-1:0] wlock_d, rlock_d, hit;

  for (genvar i = 0; i < NS; i++) begin : g_sect
    assign hit[i] = we && (sel == SW'(i));

    always_comb begin
      wlock_d[i] = wlock[i];
      rlock_d[i] = rlock[i];
      if (hit[i]) begin
        wlock_d[i] = wdata[0];
        rlock_d[i] = wdata[1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wlock[i] <= 1'b0;
        rlock[i] <= 1'b0;
      end else if (hit[i]) begin
        wlock[i] <= wlock_d[i];
        rlock[i] <= rlock_d[i];
      end
    end
  end

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable({wlock, rlock})); // R8
  AST_LOCK_BADSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (sel >= SW'(NS))) |=> $stable({wlock, rlock})); // R8
endmodule

// File: rtl/bootmap_policy.sv
module bootmap_policy
  import bootmap_pkg::*;
#(
  parameter int unsigned NS = N_FINE,
  parameter int unsigned SW = SECT_W,
  parameter int unsigned UW = UNI_W
) (
  input  logic [1:0]    op,
  input  logic [SW-1:0] fine_idx,
  input  logic [UW-1:0] uni_idx,
  input  logic          tbl_n,
  input  logic          wp_n,
  input  logic [NS-1:0] wlock,
  input  logic [NS-1:0] rlock,
  output logic          allow,
  output logic [SW-1:0] sector
);
  localparam logic [SW-1:0] BOOT_FINE = SW'(NS - 1);
  localparam logic [UW-1:0] BOOT_UNI  = {UW{1'b1}};
  localparam int unsigned   TOP_LO    = 3;  // first fine sector inside the top 64 KB

  logic          in_boot, hw_block, reg_block;
  logic [NS-1:0] top_mask;

  for (genvar i = 0; i < NS; i++) begin : g_mask
    assign top_mask[i] = (i >= TOP_LO);
  end

  always_comb begin
    in_boot   = 1'b0;
    hw_block  = 1'b0;
    reg_block = 1'b0;
    sector    = fine_idx;
    allow     = 1'b0;
    unique case (op_e'(op))
      OP_READ: begin
        allow = !rlock[fine_idx];
      end
      OP_PROG, OP_ERASE_FINE: begin
        in_boot   = (fine_idx == BOOT_FINE);
        hw_block  = in_boot ? !tbl_n : !wp_n;
        reg_block = wlock[fine_idx];
        allow     = !hw_block && !reg_block;
      end
      OP_ERASE_UNI: begin
        sector    = SW'(uni_idx);
        in_boot   = (uni_idx == BOOT_UNI);
        hw_block  = in_boot ? !tbl_n : !wp_n;
        reg_block = in_boot ? |(wlock & top_mask) : wlock[uni_idx];
        allow     = !hw_block && !reg_block;
      end
      default: allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/bootmap_guard.sv
module bootmap_guard
  import bootmap_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NS = N_FINE,
  parameter int unsigned SW = SECT_W,
  parameter int unsigned UW = UNI_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic          tbl_n,
  input  logic          wp_n,
  input  logic          lk_we,
  input  logic [SW-1:0] lk_sel,
  input  logic [1:0]    lk_wdata,
  output logic          rsp_vld,
  output logic          rsp_allow,
  output logic          rsp_deny,
  output logic [SW-1:0] rsp_sector
);
  localparam logic [AW-1:0] BOOT_BASE = AW'(((1 << AW) - 1) & ~((1 << (AW - 4)) - 1));

  logic          rst_meta, rst_sync_n;
  logic [SW-1:0] fine_idx, pol_sector;
  logic [UW-1:0] uni_idx;
  logic [NS-1:0] wlock, rlock;
  logic          pol_allow;
  logic          vld_d, allow_d, deny_d;
  logic [SW-1:0] sect_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  bootmap_decode #(.AW(AW), .SW(SW), .UW(UW)) u_decode (
    .addr     (req_addr),
    .fine_idx (fine_idx),
    .uni_idx  (uni_idx)
  );

  bootmap_lockbank #(.NS(NS), .SW(SW)) u_locks (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (lk_we),
    .sel   (lk_sel),
    .wdata (lk_wdata),
    .wlock (wlock),
    .rlock (rlock)
  );

  bootmap_policy #(.NS(NS), .SW(SW), .UW(UW)) u_policy (
    .op       (req_op),
    .fine_idx (fine_idx),
    .uni_idx  (uni_idx),
    .tbl_n    (tbl_n),
    .wp_n     (wp_n),
    .wlock    (wlock),
    .rlock    (rlock),
    .allow    (pol_allow),
    .sector   (pol_sector)
  );

  always_comb begin
    vld_d   = req_vld;
    allow_d = req_vld && pol_allow;
    deny_d  = req_vld && !pol_allow;
    sect_d  = req_vld ? pol_sector : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_vld    <= 1'b0;
      rsp_allow  <= 1'b0;
      rsp_deny   <= 1'b0;
      rsp_sector <= '0;
    end else begin
      rsp_vld    <= vld_d;
      rsp_allow  <= allow_d;
      rsp_deny   <= deny_d;
      rsp_sector <= sect_d;
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_vld |=> (rsp_vld && (rsp_allow != rsp_deny))); // R9
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_vld |=> (!rsp_vld && !rsp_allow && !rsp_deny)); // R9
  AST_TBL_BOOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_vld && !tbl_n && (req_op == OP_PROG || req_op == OP_ERASE_FINE) &&
     (req_addr >= BOOT_BASE)) |=> rsp_deny); // R3
  AST_TBL_UNI: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_vld && !tbl_n && (req_op == OP_ERASE_UNI) &&
     (req_addr[AW-1 -: 2] == 2'b11)) |=> (rsp_deny && (rsp_sector == SW'(3)))); // R4
  AST_WP_MAIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_vld && !wp_n && (req_op != OP_READ) &&
     ((req_op == OP_ERASE_UNI) ? (req_addr[AW-1 -: 2] != 2'b11)
                               : (req_addr < BOOT_BASE))) |=> rsp_deny); // R5
endmodule

// File: tb/bootmap_guard_tb.sv
`timescale 1ns/1ps
module bootmap_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [17:0] req_addr = '0;
  logic        tbl_n = 1'b1;
  logic        wp_n = 1'b1;
  logic        lk_we = 1'b0;
  logic [2:0]  lk_sel = '0;
  logic [1:0]  lk_wdata = '0;
  logic        rsp_vld, rsp_allow, rsp_deny;
  logic [2:0]  rsp_sector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [6:0] m_wl = '0;
  logic [6:0] m_rl = '0;

  always #2 clk = ~clk;

  bootmap_guard u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
    .req_addr(req_addr), .tbl_n(tbl_n), .wp_n(wp_n), .lk_we(lk_we),
    .lk_sel(lk_sel), .lk_wdata(lk_wdata), .rsp_vld(rsp_vld),
    .rsp_allow(rsp_allow), .rsp_deny(rsp_deny), .rsp_sector(rsp_sector)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fine_of(input int a);
    if (a >= 32'h3C000) return 6;
    if (a >= 32'h3A000) return 5;
    if (a >= 32'h38000) return 4;
    if (a >= 32'h30000) return 3;
    return a / 32'h10000;
  endfunction

  task automatic lock_wr(input int sel, input logic [1:0] d);
    @(negedge clk);
    lk_we = 1'b1; lk_sel = 3'(sel); lk_wdata = d;
    @(negedge clk);
    lk_we = 1'b0;
  endtask

  task automatic set_locks(input logic [6:0] wl, input logic [6:0] rl);
    for (int i = 0; i < 7; i++) lock_wr(i, {rl[i], wl[i]});
    m_wl = wl; m_rl = rl;
  endtask

  task automatic do_req(input int op, input int a);
    int f, s, exp_allow;
    bit boot;
    string tag;
    @(negedge clk);
    req_vld = 1'b1; req_op = 2'(op); req_addr = 18'(a);
    @(negedge clk);
    req_vld = 1'b0;
    f = fine_of(a);
    if (op == 0) begin
      s = f; exp_allow = !m_rl[f]; tag = "R7 read verdict";
    end else if (op == 3) begin
      s = a / 32'h10000;
      boot = (s == 3);
      if (boot) exp_allow = tbl_n && ((m_wl & 7'h78) == 0);
      else      exp_allow = wp_n && !m_wl[s];
      tag = boot ? (!tbl_n ? "R4 uniform boot" : "R6 uniform lock")
                 : (!wp_n ? "R5 uniform wp" : "R6 uniform lock");
    end else begin
      s = f;
      boot = (f == 6);
      exp_allow = (boot ? tbl_n : wp_n) && !m_wl[f];
      tag = boot ? (!tbl_n ? "R3 boot pin" : "R6 fine lock")
                 : (!wp_n ? "R5 wp pin" : (f >= 3 ? "R4 R6 top subsector" : "R6 fine lock"));
    end
    chk("R9 rsp_vld after strobe", int'(rsp_vld), 1);
    chk(tag, int'(rsp_allow), exp_allow);
    chk("R9 deny complement", int'(rsp_deny), 1 - exp_allow);
    chk(op == 3 ? "R2 uniform sector" : "R1 fine sector", int'(rsp_sector), s);
    @(negedge clk);
    chk("R9 quiet without strobe", int'({rsp_vld, rsp_allow, rsp_deny}), 0);
  endtask

  task automatic sweep();
    for (int p = 0; p < 4; p++) begin
      tbl_n = p[0]; wp_n = p[1];
      for (int op = 0; op < 4; op++)
        for (int b = 0; b < 32; b++) begin
          do_req(op, b * 32'h2000);
          do_req(op, b * 32'h2000 + 32'h1FFF);
        end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", int'({rsp_vld, rsp_allow, rsp_deny, rsp_sector}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 idle after reset", int'({rsp_vld, rsp_allow, rsp_deny}), 0);
    // R8: locks clear after reset, checked by the first sweep with a clear model
    sweep();
    for (int c = 1; c <= 8; c++) begin
      if (c == 8) set_locks(7'h7F, 7'h7F);
      else        set_locks(7'(1 << (c - 1)), 7'(1 << (7 - c)));
      sweep();
    end
    // R8: select 7 must not touch any sector
    set_locks('0, '0);
    lock_wr(7, 2'b11);
    tbl_n = 1'b1; wp_n = 1'b1;
    for (int b = 0; b < 32; b++) begin
      do_req(0, b * 32'h2000);
      do_req(1, b * 32'h2000 + 32'h1FFF);
    end
    do_req(3, 32'h3A123);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule